// File: doc/BRIEF.md
# Register Write Command Executor

This block plays back a list of register-write commands that software has placed in memory. Software first sets the enable bit while the engine is idle. It then loads a start byte address and writes an end byte address. Writing the end address launches a run. The engine walks memory one 32-bit word at a time over a request/valid read port. It decodes each 8-byte command slot and issues writes, with byte enables, on a local register-write port. The busy status stays high until the fetch pointer reaches the end address.

Two command formats are understood. A direct slot carries one data word, followed by a control word. The control word holds an opcode, four byte enables and a 20-bit register offset. A block slot starts with a count word and a control word, then carries that many data words, all aimed at one register offset. A zero word follows when needed to bring the next command back onto an 8-byte boundary. Software rounds the end address up to a 64-byte multiple and fills the gap with zero words. The engine treats an all-zero slot as a no-operation. It skips any slot with an unknown opcode and raises a sticky error flag.

Top module: `cmdexec_top`

## Requirements
- R1: After reset, st_busy, st_err, st_enable, mem_req and reg_we are all 0.
- R2: Writing address 2 (end pointer) while idle, with the enable bit set and a value that differs from the stored start pointer, makes st_busy 1 on the following clock. With the enable bit clear, or with a value equal to the start pointer, the write starts no run: st_busy stays 0 and no memory read is issued.
- R3: During a run, reads go to word addresses (byte address / 4) that start at the start pointer and strictly increase. No read is issued outside a run, and a read request is never asserted on two consecutive cycles.
- R4: A slot whose second word has opcode 0x01 in bits 31:24 produces one register write. The write takes its data from the first word, its byte enables from bits 23:20 of the second word, and its offset from bits 19:0 of the second word.
- R5: A slot whose second word has opcode 0x09 takes its first word as a count N. It produces N writes, in memory order, of the following N words, each to offset bits 19:0 with byte enables 4'hF. When N is odd, the single zero pad word that follows is skipped.
- R6: A slot whose two words are both zero produces no write and leaves st_err unchanged.
- R7: A slot whose second word has any other opcode (and is not all-zero with the first) is skipped as 8 bytes with no write, and sets st_err. st_err stays 1 until the next run starts, which clears it.
- R8: st_busy falls once the slot ending at the end pointer has been consumed and every write has appeared on the register port. reg_we is asserted only while st_busy is 1.
- R9: While st_busy is 1, writes to address 0 (control, bit 0 = enable), address 1 (start pointer) and address 2 (end pointer) have no effect.
- R10: A block slot with count 0 produces no write and advances by exactly one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Control register write strobe |
| csr_addr | input | 2 | 0 = control, 1 = start pointer, 2 = end pointer |
| csr_wdata | input | AW | Control write data (byte address, or bit 0 = enable) |
| st_enable | output | 1 | Enable bit as stored |
| st_busy | output | 1 | Run in progress |
| st_err | output | 1 | Sticky unknown-opcode flag |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | AW-2 | Word address of the read |
| mem_rvalid | input | 1 | Read data valid, one or more cycles after the request |
| mem_rdata | input | 32 | Read data word |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | 20 | Register offset |
| reg_be | output | 4 | Byte enables |
| reg_wdata | output | 32 | Register write data |

## Verification
The properties assume a well-formed command list whose start is 8-byte aligned and whose end is a 64-byte multiple. They also assume memory answers each request with exactly one valid pulse, at least one cycle later. The bench keeps within this: every stream is built by helper tasks that append whole slots and then zero-fill up to the next 64-byte boundary. The memory model answers each request after a random delay of one to three cycles. Random streams mix direct, block, no-op and bad slots with random data, offsets and byte enables.

// File: rtl/cmdexec_pkg.sv
package cmdexec_pkg;

    localparam int DW    = 32;
    localparam int OFF_W = 20;
    localparam int BE_W  = 4;

    localparam logic [7:0] OP_DIRECT  = 8'h01;
    localparam logic [7:0] OP_INDEXED = 8'h09;

    localparam logic [1:0] CSR_CTRL = 2'd0;
    localparam logic [1:0] CSR_HEAD = 2'd1;
    localparam logic [1:0] CSR_TAIL = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ_A,
        S_WAIT_A,
        S_REQ_B,
        S_WAIT_B,
        S_EXEC,
        S_REQ_D,
        S_WAIT_D
    } seq_state_e;

    typedef enum logic [1:0] {
        K_DIRECT,
        K_INDEXED,
        K_NOP,
        K_BAD
    } slot_kind_e;

    typedef struct packed {
        logic [7:0]       op;
        logic [BE_W-1:0]  be;
        logic [OFF_W-1:0] off;
    } ctl_word_t;

    typedef struct packed {
        logic             valid;
        logic [OFF_W-1:0] off;
        logic [BE_W-1:0]  be;
        logic [DW-1:0]    data;
    } wr_req_t;

    function automatic slot_kind_e classify(input logic [DW-1:0] w0, input ctl_word_t w1);
        if (w1.op == OP_DIRECT)
            return K_DIRECT;
        else if (w1.op == OP_INDEXED)
            return K_INDEXED;
        else if (w0 == '0 && w1 == '0)
            return K_NOP;
        else
            return K_BAD;
    endfunction

endpackage

// File: rtl/cmdexec_csr.sv
module cmdexec_csr
    import cmdexec_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          csr_we,
    input  logic [1:0]    csr_addr,
    input  logic [AW-1:0] csr_wdata,
    input  logic          busy,
    output logic          enable,
    output logic [AW-1:0] head,
    output logic [AW-1:0] tail,
    output logic          start
);

    logic idle_wr;

    assign idle_wr = csr_we && !busy;
    assign start   = idle_wr && (csr_addr == CSR_TAIL) && enable && (csr_wdata != head);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= 1'b0;
            head   <= '0;
            tail   <= '0;
        end else if (idle_wr) begin
            case (csr_addr)
                CSR_CTRL: enable <= csr_wdata[0];
                CSR_HEAD: head   <= csr_wdata;
                CSR_TAIL: tail   <= csr_wdata;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/cmdexec_seq.sv
module cmdexec_seq
    import cmdexec_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] head,
    input  logic [AW-1:0] tail,
    output logic          mem_req,
    output logic [AW-3:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          err,
    output wr_req_t       wr
);

    seq_state_e       state;
    logic [AW-1:0]    ptr;
    logic [DW-1:0]    w0;
    ctl_word_t        w1;
    logic [DW-1:0]    cnt;
    logic [OFF_W-1:0] blk_off;
    slot_kind_e       kind;
    logic [AW-1:0]    ptr_inc;
    logic [AW-1:0]    ptr_aln;
    logic             at_end;

    assign kind    = classify(w0, w1);
    assign ptr_inc = ptr + AW'(4);
    assign ptr_aln = {ptr_inc[AW-1:3] + (AW-3)'(|ptr_inc[2:0]), 3'b000};
    assign at_end  = (ptr == tail);

    assign busy     = (state != S_IDLE);
    assign mem_addr = ptr[AW-1:2];
    assign mem_req  = (state == S_REQ_A && !at_end) || (state == S_REQ_B) || (state == S_REQ_D);

    always_comb begin
        wr = '0;
        if (state == S_EXEC && kind == K_DIRECT) begin
            wr.valid = 1'b1;
            wr.off   = w1.off;
            wr.be    = w1.be;
            wr.data  = w0;
        end else if (state == S_WAIT_D && mem_rvalid) begin
            wr.valid = 1'b1;
            wr.off   = blk_off;
            wr.be    = '1;
            wr.data  = mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            ptr     <= '0;
            w0      <= '0;
            w1      <= '0;
            cnt     <= '0;
            blk_off <= '0;
            err     <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        ptr   <= head;
                        err   <= 1'b0;
                        state <= S_REQ_A;
                    end
                end
                S_REQ_A: state <= at_end ? S_IDLE : S_WAIT_A;
                S_WAIT_A: begin
                    if (mem_rvalid) begin
                        w0    <= mem_rdata;
                        ptr   <= ptr_inc;
                        state <= S_REQ_B;
                    end
                end
                S_REQ_B: state <= S_WAIT_B;
                S_WAIT_B: begin
                    if (mem_rvalid) begin
                        w1    <= mem_rdata;
                        ptr   <= ptr_inc;
                        state <= S_EXEC;
                    end
                end
                S_EXEC: begin
                    state <= S_REQ_A;
                    case (kind)
                        K_INDEXED: begin
                            cnt     <= w0;
                            blk_off <= w1.off;
                            if (w0 != '0)
                                state <= S_REQ_D;
                        end
                        K_BAD:   err <= 1'b1;
                        default: ;
                    endcase
                end
                S_REQ_D: state <= S_WAIT_D;
                S_WAIT_D: begin
                    if (mem_rvalid) begin
                        cnt <= cnt - DW'(1);
                        if (cnt == DW'(1)) begin
                            ptr   <= ptr_aln;
                            state <= S_REQ_A;
                        end else begin
                            ptr   <= ptr_inc;
                            state <= S_REQ_D;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cmdexec_wrport.sv
module cmdexec_wrport
    import cmdexec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          wr,
    output logic             reg_we,
    output logic [OFF_W-1:0] reg_addr,
    output logic [BE_W-1:0]  reg_be,
    output logic [DW-1:0]    reg_wdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_we    <= 1'b0;
            reg_addr  <= '0;
            reg_be    <= '0;
            reg_wdata <= '0;
        end else begin
            reg_we <= wr.valid;
            if (wr.valid) begin
                reg_addr  <= wr.off;
                reg_be    <= wr.be;
                reg_wdata <= wr.data;
            end
        end
    end

endmodule

// File: rtl/cmdexec_top.sv
module cmdexec_top
    import cmdexec_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_we,
    input  logic [1:0]       csr_addr,
    input  logic [AW-1:0]    csr_wdata,
    output logic             st_enable,
    output logic             st_busy,
    output logic             st_err,
    output logic             mem_req,
    output logic [AW-3:0]    mem_addr,
    input  logic             mem_rvalid,
    input  logic [DW-1:0]    mem_rdata,
    output logic             reg_we,
    output logic [OFF_W-1:0] reg_addr,
    output logic [BE_W-1:0]  reg_be,
    output logic [DW-1:0]    reg_wdata
);

    logic [AW-1:0] head;
    logic [AW-1:0] tail;
    logic          start;
    wr_req_t       wr;

    cmdexec_csr #(.AW(AW)) u_csr (
        .clk       (clk),
        .rst       (rst),
        .csr_we    (csr_we),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .busy      (st_busy),
        .enable    (st_enable),
        .head      (head),
        .tail      (tail),
        .start     (start)
    );

    cmdexec_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .head       (head),
        .tail       (tail),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .busy       (st_busy),
        .err        (st_err),
        .wr         (wr)
    );

    cmdexec_wrport u_wrport (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_be    (reg_be),
        .reg_wdata (reg_wdata)
    );

endmodule

// File: rtl/cmdexec_chk.sv
module cmdexec_chk (
    input logic       clk,
    input logic       rst,
    input logic       csr_we,
    input logic [1:0] csr_addr,
    input logic       st_enable,
    input logic       st_busy,
    input logic       st_err,
    input logic       mem_req,
    input logic       reg_we
);

    AST_WRITE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> st_busy); // R8

    AST_FETCH_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> st_busy); // R3

    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req); // R3

    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_addr == 2'd2 && !st_enable && !st_busy) |=> !st_busy); // R2

    AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (st_busy && csr_we && csr_addr == 2'd0) |=> $stable(st_enable)); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st_err && !(csr_we && csr_addr == 2'd2)) |=> st_err); // R7

endmodule

bind cmdexec_top cmdexec_chk u_chk (.*);

// File: tb/cmdexec_top_tb.sv
`timescale 1ns/1ps
module cmdexec_top_tb;

    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          csr_we = 1'b0;
    logic [1:0]    csr_addr = '0;
    logic [AW-1:0] csr_wdata = '0;
    logic          st_enable, st_busy, st_err;
    logic          mem_req;
    logic [AW-3:0] mem_addr;
    logic          mem_rvalid = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          reg_we;
    logic [19:0]   reg_addr;
    logic [3:0]    reg_be;
    logic [31:0]   reg_wdata;

    always #2 clk = ~clk;

    cmdexec_top #(.AW(AW)) u_dut (.*);

    logic [31:0] mem [0:1023];
    int          wp;
    logic [19:0] exp_addr [0:127];
    logic [3:0]  exp_be   [0:127];
    logic [31:0] exp_data [0:127];
    int          exp_n;
    bit          exp_err;
    logic [19:0] got_addr [0:127];
    logic [3:0]  got_be   [0:127];
    logic [31:0] got_data [0:127];
    int          got_n;
    int          req_n;
    int          req_first;
    int          req_last;
    bit          req_mono;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          pend = 0;
    int          pend_addr;
    int          pend_wait;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // memory responder and output capture, both on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (pend) begin
                if (pend_wait == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem[pend_addr];
                    pend       = 0;
                end else begin
                    pend_wait--;
                end
            end
            if (mem_req) begin
                pend      = 1;
                pend_addr = int'(mem_addr);
                pend_wait = int'($urandom % 3);
                if (req_n > 0 && int'(mem_addr) <= req_last) req_mono = 0;
                if (req_n == 0) req_first = int'(mem_addr);
                req_last = int'(mem_addr);
                req_n++;
            end
            if (reg_we) begin
                if (!st_busy) chk(0, "R8", "write outside run", 1, 0);
                if (got_n < 128) begin
                    got_addr[got_n] = reg_addr;
                    got_be[got_n]   = reg_be;
                    got_data[got_n] = reg_wdata;
                end
                got_n++;
            end
        end
    end

    task automatic csr_write(input logic [1:0] a, input int v);
        csr_we    = 1'b1;
        csr_addr  = a;
        csr_wdata = AW'(v);
        @(negedge clk);
        csr_we    = 1'b0;
    endtask

    task automatic begin_stream(input int base);
        for (int i = base; i < base + 112 && i < 1024; i++) mem[i] = '0;
        wp      = base;
        exp_n   = 0;
        exp_err = 0;
    endtask

    task automatic add_direct(input logic [31:0] d, input logic [19:0] off, input logic [3:0] be);
        mem[wp]     = d;
        mem[wp + 1] = {8'h01, be, off};
        wp += 2;
        exp_addr[exp_n] = off; exp_be[exp_n] = be; exp_data[exp_n] = d;
        exp_n++;
    endtask

    task automatic add_indexed(input int n, input logic [19:0] off);
        mem[wp]     = 32'(n);
        mem[wp + 1] = {8'h09, 4'h0, off};
        wp += 2;
        for (int k = 0; k < n; k++) begin
            logic [31:0] d;
            d = $urandom;
            mem[wp] = d;
            wp++;
            exp_addr[exp_n] = off; exp_be[exp_n] = 4'hF; exp_data[exp_n] = d;
            exp_n++;
        end
        if (wp % 2 != 0) begin
            mem[wp] = '0;
            wp++;
        end
    endtask

    task automatic add_nop();
        mem[wp] = '0; mem[wp + 1] = '0;
        wp += 2;
    endtask

    task automatic add_bad(input logic [7:0] op);
        mem[wp]     = $urandom;
        mem[wp + 1] = {op, 4'hA, 20'h00777};
        wp += 2;
        exp_err = 1;
    endtask

    function automatic int tail_of(input int w);
        return ((w + 15) / 16) * 16 * 4;
    endfunction

    task automatic clear_capture();
        got_n = 0; req_n = 0; req_mono = 1; req_first = -1; req_last = -1;
    endtask

    task automatic wait_idle(output bit ok);
        ok = 0;
        for (int c = 0; c < 4000; c++) begin
            if (!st_busy) begin ok = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic compare_run(input string tag, input int head_b, input int tail_b);
        chk(got_n == exp_n, tag, "write count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            chk(got_addr[i] == exp_addr[i], tag, "write offset", got_addr[i], exp_addr[i]);
            chk(got_be[i]   == exp_be[i],   tag, "write byte enables", got_be[i], exp_be[i]);
            chk(got_data[i] == exp_data[i], tag, "write data", got_data[i], exp_data[i]);
        end
        chk(st_err == exp_err, "R7", "error flag", st_err, exp_err);
        chk(req_first == head_b / 4, "R3", "first read address", req_first, head_b / 4);
        chk(req_mono, "R3", "read addresses ascend", req_mono, 1);
        chk(req_last < tail_b / 4, "R3", "last read below end", req_last, tail_b / 4);
    endtask

    task automatic run(input string tag, input int head_b, input int tail_b, input bit load_head);
        bit ok;
        clear_capture();
        if (load_head) csr_write(2'd1, head_b);
        csr_write(2'd2, tail_b);
        chk(st_busy == 1'b1, "R2", "busy one clock after end write", st_busy, 1);
        wait_idle(ok);
        chk(ok, "R8", "run finished", ok, 1);
        compare_run(tag, head_b, tail_b);
    endtask

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        clear_capture();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(!st_busy,   "R1", "busy after reset", st_busy, 0);
        chk(!st_err,    "R1", "err after reset", st_err, 0);
        chk(!st_enable, "R1", "enable after reset", st_enable, 0);
        chk(!mem_req,   "R1", "mem_req after reset", mem_req, 0);
        chk(!reg_we,    "R1", "reg_we after reset", reg_we, 0);

        // R2 end write while disabled
        begin_stream(0); add_direct(32'h1, 20'h1, 4'hF);
        csr_write(2'd1, 0);
        csr_write(2'd2, 64);
        repeat (4) @(negedge clk);
        chk(!st_busy && req_n == 0, "R2", "disabled end write starts nothing", req_n, 0);

        // R2 end equal to start
        csr_write(2'd0, 1);
        chk(st_enable, "R2", "enable set", st_enable, 1);
        csr_write(2'd1, 128);
        csr_write(2'd2, 128);
        repeat (4) @(negedge clk);
        chk(!st_busy && req_n == 0, "R2", "end equal start starts nothing", req_n, 0);

        // directed stream: R4 R5 R10 R6 R7
        begin_stream(32);
        add_direct(32'hA5A5_0001, 20'h01234, 4'h5);
        add_indexed(3, 20'h00400);
        add_indexed(0, 20'h00500);
        add_nop();
        add_bad(8'h05);
        add_direct(32'h0, 20'hFFFFF, 4'hF);
        add_indexed(2, 20'h00ABC);
        run("R4 R5 R10 R6", 128, tail_of(wp), 1'b1);
        repeat (3) @(negedge clk);
        chk(st_err, "R7", "err held while idle", st_err, 1);

        // R9: run again from the same start, poking registers while busy
        clear_capture();
        csr_write(2'd2, tail_of(wp));
        csr_write(2'd1, 12'h300);
        csr_write(2'd0, 0);
        csr_write(2'd2, 12'h3C0);
        chk(st_busy, "R9", "still busy after pokes", st_busy, 1);
        begin
            bit ok;
            wait_idle(ok);
            chk(ok, "R8", "run finished", ok, 1);
        end
        chk(st_enable, "R9", "enable unchanged by busy write", st_enable, 1);
        compare_run("R9", 128, tail_of(wp));
        clear_capture();
        csr_write(2'd2, tail_of(wp));
        begin
            bit ok;
            wait_idle(ok);
        end
        compare_run("R9", 128, tail_of(wp));

        // R7 clearing: run with no bad slot
        begin_stream(400);
        add_nop();
        add_direct(32'hDEAD_BEEF, 20'h00010, 4'h8);
        run("R7 R6", 1600, tail_of(wp), 1'b1);

        // random streams
        for (int r = 0; r < 12; r++) begin
            int base;
            base = 2 * int'($urandom % 300);
            begin_stream(base);
            for (int e = 0; e < 1 + int'($urandom % 6); e++) begin
                case ($urandom % 4)
                    0: add_direct($urandom, 20'($urandom), 4'($urandom));
                    1: add_indexed(int'($urandom % 5), 20'($urandom));
                    2: add_nop();
                    default: add_bad(($urandom % 2) ? 8'hFF : 8'h02);
                endcase
            end
            run("R4 R5 R6 R7", base * 4, tail_of(wp), 1'b1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_vec++;
        n_bad++;
        $display("FAIL R8 watchdog: actual %0h expected %0h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule